// File: doc/BRIEF.md
# Folded Word Memory with Predecoded Row Selection

This block is a synchronous single-port memory holding 2048 words of 16 bits. Instead of one storage row per word, the words are packed eight to a row, giving 256 rows of 128 bit cells. An 11-bit address is split in two. The upper eight bits choose one row. The lower three bits choose one word inside that row.

Row selection works in two steps. The eight row bits are taken two at a time, and each pair is decoded into a group of four lines, exactly one of them high. Each of the 256 row lines is then the AND of one line from each of the four groups. Inside the selected row, each of the 16 data bits has its own eight-way column selector. The eight copies of a data bit sit in neighbouring cells: data bit b of in-row word c is stored in cell b*8 + c.

Each cycle performs either one read or one write. Read data is registered. The one-hot row vector is brought out as a port so that the address decode can be observed.

Top module: `folded_sram`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0 at every clock edge.
- R2: `row_sel` has exactly one bit set for every address value.
- R3: The bit set in `row_sel` is the bit whose index equals `addr[10:3]`.
- R4: In a cycle with `we` = 0, `rdata` after the clock edge equals the word last written to `addr`.
- R5: In a cycle with `we` = 1, `wdata` is stored at `addr`. The other seven words that share the row (same `addr[10:3]`, different `addr[2:0]`) keep their contents.
- R6: In a cycle with `we` = 1, `rdata` keeps the value it had before the clock edge.
- R7: All 2048 addresses hold separate words. After every address has been written with its own value, reading each address returns that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on the rising edge |
| rst_n | input | 1 | Active-low reset of the read-data register |
| addr | input | 11 | Word address: bits [10:3] select the row, bits [2:0] select the word within the row |
| we | input | 1 | 1 = write this cycle, 0 = read this cycle |
| wdata | input | 16 | Data to write |
| rdata | output | 16 | Registered read data |
| row_sel | output | 256 | One-hot row select decoded from `addr[10:3]` |

## Verification
The main function is exercised with several input patterns:
- A fill of every address with a value derived from the address itself, followed by a full read-back. This separates all 2048 storage locations, so any row or column aliasing shows up.
- Bursts that write one in-row word and then read its seven row neighbours. These expose a write mask that spills into adjacent cells of the same row.
- Alternating read-after-write to a single address. This exposes read-register holding or ordering faults.
- A long random mix of reads and writes, together with a sweep of every address. The sweep checks that the row select is one-hot and sits at the expected position.

// File: rtl/folded_sram.sv
module folded_sram #(
  parameter int ROW_AW = 8,
  parameter int COL_AW = 3,
  parameter int DW     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ROW_AW+COL_AW-1:0]   addr,
  input  logic                       we,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [(1<<ROW_AW)-1:0]     row_sel
);
  localparam int ROWS = 1 << ROW_AW;
  localparam int MUX  = 1 << COL_AW;
  localparam int COLS = DW * MUX;
  localparam int GRP  = ROW_AW / 2;

  logic [3:0]      pre [GRP];
  logic [MUX-1:0]  colsel;
  logic [COLS-1:0] wmask, wspread, row_q;
  logic [COLS-1:0] mem [ROWS];
  logic [DW-1:0]   rd_d;
  logic [COL_AW-1:0] col;

  assign col    = addr[COL_AW-1:0];
  assign colsel = MUX'(1) << col;

  for (genvar g = 0; g < GRP; g++) begin : g_pre
    assign pre[g] = 4'b0001 << addr[COL_AW+2*g +: 2];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int g = 0; g < GRP; g++)
        hit = hit & pre[g][(r >> (2*g)) & 3];
    end
    assign row_sel[r] = hit;

    always_ff @(posedge clk)
      if (hit) mem[r] <= (mem[r] & ~wmask) | (wspread & wmask);
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    for (genvar c = 0; c < MUX; c++) begin : g_col
      assign wmask[b*MUX+c]   = we & colsel[c];
      assign wspread[b*MUX+c] = wdata[b];
    end
    assign rd_d[b] = row_q[b*MUX + int'(col)];
  end

  always_comb begin
    row_q = '0;
    for (int r = 0; r < ROWS; r++)
      if (row_sel[r]) row_q = row_q | mem[r];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   rdata <= '0;
    else if (!we) rdata <= rd_d;

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> rdata == '0);

  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);

  assert_row_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    row_sel[addr[ROW_AW+COL_AW-1:COL_AW]]);

  assert_write_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we ##1 (!we && addr == $past(addr)) |=> rdata == $past(wdata, 2));

  assert_hold_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $stable(rdata));
endmodule

// File: tb/sim_folded_sram.sv
`timescale 1ns/1ps
module sim_folded_sram;
  logic        clk = 0, rst_n = 0, we = 0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [255:0] row_sel;
  int tests = 0, fails = 0;
  logic [15:0] model [2048];
  logic [15:0] exp_rd = '0;

  folded_sram u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
                  .wdata(wdata), .rdata(rdata), .row_sel(row_sel));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [10:0] a, input bit w, input logic [15:0] d, input string req);
    @(negedge clk);
    addr = a; we = w; wdata = d;
    #1;
    chk($countones(row_sel) == 1, "R2", 256'($countones(row_sel)), 256'd1);
    chk(row_sel == (256'd1 << a[10:3]), "R3", row_sel, 256'd1 << a[10:3]);
    if (!w) exp_rd = model[a];
    else model[a] = d;
    @(posedge clk); #1;
    chk(rdata == exp_rd, w ? "R6" : req, 256'(rdata), 256'(exp_rd));
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h9E37) ^ (a << 5) ^ 16'h5A5A);
  endfunction

  initial begin
    #100000000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk(rdata == 16'd0, "R1", 256'(rdata), 256'd0);
    @(negedge clk); rst_n = 1;

    for (int a = 0; a < 2048; a++) step(11'(a), 1, pat(a), "R7");
    for (int a = 0; a < 2048; a++) step(11'(a), 0, 16'hFFFF, "R7");

    for (int row = 0; row < 256; row += 37) begin
      for (int c = 0; c < 8; c++) begin
        step(11'((row << 3) | c), 1, 16'hFFFF ^ 16'(c), "R5");
        for (int n = 0; n < 8; n++) step(11'((row << 3) | n), 0, 16'h0, "R5");
      end
    end

    for (int i = 0; i < 40; i++) begin
      step(11'd1234, 1, 16'(i * 911), "R4");
      step(11'd1234, 0, 16'h0, "R4");
    end

    for (int i = 0; i < 6000; i++) begin
      logic [10:0] a;
      a = 11'($urandom);
      step(a, 1'($urandom), 16'($urandom), "R4");
    end

    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 chk(rdata == 16'd0, "R1", 256'(rdata), 256'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule